// File: doc/BRIEF.md
# Receive-Only Word-Packing Request Engine

This block runs half-duplex receive transfers, in which the host only reads data in. Software writes a byte count. The engine then asks a bit-level shifter for serial clocks until that many bytes have arrived. During the transfer the outgoing data line stays at a fixed idle level. Each incoming bit is accepted only while a clock request is active. Bits are gathered most-significant first into bytes.

Bytes are packed four to a 32-bit word, and each complete word is pushed to a receive FIFO. The configured data width of normal transfers plays no part in this mode. When fewer than four bytes are left at the end of a transfer, they go out as a final short word. A 3-bit status field states how many bytes of the most recently emitted word are valid.

A to-do counter shows how many requested bytes are still outstanding. A request written while a transfer is running adds to that counter. If the FIFO is full when a word is ready, the word is lost and a sticky overflow flag is raised. A one-cycle completion pulse marks the emission of the transfer's last word.

Top module: `rx_pack_engine`

## Requirements
- R1: After reset the to-do count is 0, the clock request and FIFO push are low, no completion pulse is given and the status word is all zeros.
- R2: A request write with a non-zero count while idle loads the to-do count and raises the clock request. The request stays high until the to-do count reaches 0 and is low in the cycle right after the final bit is accepted. A zero-count write while idle raises nothing.
- R3: The to-do count drops by exactly one for every eighth accepted bit. A bit is accepted when the bit-valid input is high while the clock request is high. The count changes in no other way except through request writes.
- R4: Bits within a byte arrive most significant bit first.
- R5: Every four received bytes form one 32-bit word, with the earliest byte in bits [31:24]. The word is pushed (push high for one cycle) two cycles after the clock edge that accepts the final bit of its fourth byte.
- R6: When the to-do count reaches 0 with one to three bytes gathered, those bytes are pushed as a short word. They are right-justified, the earliest in the most significant occupied byte, and the unused upper bytes are zero.
- R7: Status bits [30:28] hold the number of valid bytes in the most recently emitted word: 4 for a full word, 1 to 3 for a short one. The value holds until the next word is emitted.
- R8: A word ready while the FIFO-full input is high is not pushed. It sets the overflow flag in status bit 9. The flag stays set until the error-clear input is asserted.
- R9: The completion output pulses for one cycle, in the same cycle as the emission of the word holding the transfer's final byte. It pulses whether that word is pushed or dropped.
- R10: A request write during a transfer adds its count to the remaining to-do count. The sum saturates at 65535.
- R11: The transmit data output always carries the idle level (parameter, default 1). Status bit 13 (busy) is high while bytes are outstanding or a word is still on its way to the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_we_i | input | 1 | Request register write strobe |
| req_cnt_i | input | 16 | Byte count written with the strobe |
| err_clr_i | input | 1 | Clears the overflow flag |
| shift_req_o | output | 1 | Asks the shifter for serial clocks |
| tx_bit_o | output | 1 | Outgoing data line, held at idle level |
| rx_bit_vld_i | input | 1 | Shifter delivers one received bit |
| rx_bit_i | input | 1 | Received bit value |
| push_o | output | 1 | FIFO push strobe |
| push_data_o | output | 32 | Packed word for the FIFO |
| fifo_full_i | input | 1 | FIFO cannot accept a word |
| todo_o | output | 16 | Requested bytes not yet received |
| stat_o | output | 32 | Status: [30:28] valid bytes, [13] busy, [9] overflow |
| done_o | output | 1 | Transfer-complete pulse |

## Verification
The checker watches a set of properties on every cycle. The to-do count never rises without a request write. No push happens against a full FIFO. Every push shows a valid-byte count from 1 to 4. The clock request only falls once the count is empty. The overflow flag stays set without a clear, and the busy bit covers the clock request. Other behaviour only the directed scenarios can show: the exact packed word values and their byte order, the right-justified short word, the cycle in which a push appears, a single completion pulse per transfer, the addition of counts mid-transfer, and saturation.

// File: rtl/rxpk_pkg.sv
package rxpk_pkg;
  localparam int unsigned STAT_W        = 32;
  localparam int unsigned STAT_BV_LSB   = 28;
  localparam int unsigned STAT_BV_W     = 3;
  localparam int unsigned STAT_BUSY_BIT = 13;
  localparam int unsigned STAT_OVF_BIT  = 9;
endpackage

// File: rtl/rxpk_todo_ctr.sv
module rxpk_todo_ctr #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_we_i,
  input  logic [CNT_W-1:0] req_cnt_i,
  input  logic             byte_done_i,
  output logic [CNT_W-1:0] todo_o,
  output logic             shift_req_o,
  output logic             last_byte_o
);
  localparam logic [CNT_W:0] MAX_CNT = {1'b0, {CNT_W{1'b1}}};

  logic [CNT_W-1:0] todo_q;
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] todo_d;
  logic             dec;

  assign dec = byte_done_i && (todo_q != '0);

  always_comb begin
    sum = {1'b0, todo_q};
    if (dec)      sum = sum - 1'b1;
    if (req_we_i) sum = sum + {1'b0, req_cnt_i};
    todo_d = (sum > MAX_CNT) ? MAX_CNT[CNT_W-1:0] : sum[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) todo_q <= '0;
    else         todo_q <= todo_d;
  end

  assign todo_o      = todo_q;
  assign shift_req_o = (todo_q != '0);
  // final byte of the transfer: nothing left after this update
  assign last_byte_o = dec && (todo_d == '0);
endmodule

// File: rtl/rxpk_bit_gather.sv
module rxpk_bit_gather #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  input  logic              mark_i,
  output logic              byte_done_o,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              mark_o
);
  localparam int unsigned IDX_W = $clog2(BYTE_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] sh_q;
  logic [IDX_W-1:0]  idx_q;
  logic [BYTE_W-1:0] sh_d;

  assign sh_d        = {sh_q[BYTE_W-2:0], bit_i};
  assign byte_done_o = bit_vld_i && (idx_q == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q       <= '0;
      idx_q      <= '0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
      mark_o     <= 1'b0;
    end else begin
      byte_vld_o <= byte_done_o;
      if (bit_vld_i) begin
        sh_q  <= sh_d;
        idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
      end
      if (byte_done_o) begin
        byte_o <= sh_d;
        mark_o <= mark_i;
      end
    end
  end
endmodule

// File: rtl/rxpk_word_pack.sv
module rxpk_word_pack #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned BPW    = 4,
  localparam int unsigned WORD_W = BYTE_W * BPW,
  localparam int unsigned NB_W   = $clog2(BPW + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              last_i,
  input  logic              fifo_full_i,
  output logic              push_o,
  output logic [WORD_W-1:0] push_data_o,
  output logic              drop_o,
  output logic              done_o,
  output logic              pend_o,
  output logic [NB_W-1:0]   bv_o
);
  localparam logic [NB_W-1:0] FULL_N = NB_W'(BPW);

  logic [WORD_W-1:0] acc_q, acc_d, out_q;
  logic [NB_W-1:0]   n_q, n_d, bv_q;
  logic              pend_q, last_q;

  // shift left so the earliest byte ends up highest, short words right-justified
  assign acc_d = {acc_q[WORD_W-BYTE_W-1:0], byte_i};
  assign n_d   = n_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      n_q    <= '0;
      out_q  <= '0;
      bv_q   <= '0;
      pend_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      pend_q <= 1'b0;
      if (byte_vld_i) begin
        if (n_d == FULL_N || last_i) begin
          pend_q <= 1'b1;
          out_q  <= acc_d;
          bv_q   <= n_d;
          last_q <= last_i;
          acc_q  <= '0;
          n_q    <= '0;
        end else begin
          acc_q <= acc_d;
          n_q   <= n_d;
        end
      end
    end
  end

  assign push_o      = pend_q && !fifo_full_i;
  assign drop_o      = pend_q && fifo_full_i;
  assign done_o      = pend_q && last_q;
  assign push_data_o = out_q;
  assign pend_o      = pend_q;
  assign bv_o        = bv_q;
endmodule

// File: rtl/rx_pack_engine.sv
module rx_pack_engine
  import rxpk_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned BPW        = 4,
  parameter bit          IDLE_LEVEL = 1'b1,
  localparam int unsigned WORD_W    = BYTE_W * BPW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_we_i,
  input  logic [CNT_W-1:0]  req_cnt_i,
  input  logic              err_clr_i,
  output logic              shift_req_o,
  output logic              tx_bit_o,
  input  logic              rx_bit_vld_i,
  input  logic              rx_bit_i,
  output logic              push_o,
  output logic [WORD_W-1:0] push_data_o,
  input  logic              fifo_full_i,
  output logic [CNT_W-1:0]  todo_o,
  output logic [STAT_W-1:0] stat_o,
  output logic              done_o
);
  localparam int unsigned NB_W = $clog2(BPW + 1);

  logic              bit_acc, byte_done, last_byte;
  logic              byte_vld, byte_last, drop, pend;
  logic [BYTE_W-1:0] byte_val;
  logic [NB_W-1:0]   bv;
  logic              ovf_q;

  assign bit_acc = rx_bit_vld_i && shift_req_o;

  rxpk_todo_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_we_i    (req_we_i),
    .req_cnt_i   (req_cnt_i),
    .byte_done_i (byte_done),
    .todo_o      (todo_o),
    .shift_req_o (shift_req_o),
    .last_byte_o (last_byte)
  );

  rxpk_bit_gather #(.BYTE_W(BYTE_W)) u_gather (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_vld_i   (bit_acc),
    .bit_i       (rx_bit_i),
    .mark_i      (last_byte),
    .byte_done_o (byte_done),
    .byte_vld_o  (byte_vld),
    .byte_o      (byte_val),
    .mark_o      (byte_last)
  );

  rxpk_word_pack #(.BYTE_W(BYTE_W), .BPW(BPW)) u_pack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .byte_vld_i  (byte_vld),
    .byte_i      (byte_val),
    .last_i      (byte_last),
    .fifo_full_i (fifo_full_i),
    .push_o      (push_o),
    .push_data_o (push_data_o),
    .drop_o      (drop),
    .done_o      (done_o),
    .pend_o      (pend),
    .bv_o        (bv)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_q <= 1'b0;
    else if (drop)      ovf_q <= 1'b1;
    else if (err_clr_i) ovf_q <= 1'b0;
  end

  always_comb begin
    stat_o = '0;
    stat_o[STAT_BV_LSB +: STAT_BV_W] = STAT_BV_W'(bv);
    stat_o[STAT_BUSY_BIT]            = shift_req_o || byte_vld || pend;
    stat_o[STAT_OVF_BIT]             = ovf_q;
  end

  assign tx_bit_o = IDLE_LEVEL;
endmodule

// File: rtl/rx_pack_engine_chk.sv
module rx_pack_engine_chk
  import rxpk_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_we_i,
  input logic              err_clr_i,
  input logic              shift_req_o,
  input logic              push_o,
  input logic              fifo_full_i,
  input logic              done_o,
  input logic [CNT_W-1:0]  todo_o,
  input logic [STAT_W-1:0] stat_o
);
  AST_TODO_NO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_we_i |=> todo_o <= $past(todo_o)); // R3

  AST_REQ_FALL_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(shift_req_o) |-> todo_o == '0); // R2

  AST_NO_PUSH_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> !fifo_full_i); // R8

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[STAT_OVF_BIT] && !err_clr_i |=> stat_o[STAT_OVF_BIT]); // R8

  AST_BV_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> (stat_o[STAT_BV_LSB +: STAT_BV_W] != 3'd0 &&
                stat_o[STAT_BV_LSB +: STAT_BV_W] <= 3'd4)); // R7

  AST_DONE_WITH_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (push_o || fifo_full_i)); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9

  AST_BUSY_COVERS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_req_o |-> stat_o[STAT_BUSY_BIT]); // R11
endmodule

bind rx_pack_engine rx_pack_engine_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_we_i    (req_we_i),
  .err_clr_i   (err_clr_i),
  .shift_req_o (shift_req_o),
  .push_o      (push_o),
  .fifo_full_i (fifo_full_i),
  .done_o      (done_o),
  .todo_o      (todo_o),
  .stat_o      (stat_o)
);

// File: tb/rx_pack_engine_test.sv
`timescale 1ns/1ps
module rx_pack_engine_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_we_i = 1'b0;
  logic [15:0] req_cnt_i = '0;
  logic        err_clr_i = 1'b0;
  logic        shift_req_o, tx_bit_o;
  logic        rx_bit_vld_i = 1'b0;
  logic        rx_bit_i = 1'b0;
  logic        push_o;
  logic [31:0] push_data_o;
  logic        fifo_full_i = 1'b0;
  logic [15:0] todo_o;
  logic [31:0] stat_o;
  logic        done_o;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  logic [31:0] cap_data [0:15];
  logic [2:0]  cap_bv   [0:15];
  int          cap_n = 0;
  int          done_n = 0;

  always #2 clk_i = ~clk_i;

  rx_pack_engine uut (
    .clk_i, .rst_ni, .req_we_i, .req_cnt_i, .err_clr_i,
    .shift_req_o, .tx_bit_o, .rx_bit_vld_i, .rx_bit_i,
    .push_o, .push_data_o, .fifo_full_i, .todo_o, .stat_o, .done_o
  );

  always @(negedge clk_i) begin
    if (push_o && cap_n < 16) begin
      cap_data[cap_n] = push_data_o;
      cap_bv[cap_n]   = stat_o[30:28];
      cap_n++;
    end
    if (done_o) done_n++;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_caps();
    @(negedge clk_i);
    cap_n = 0;
    done_n = 0;
  endtask

  task automatic write_req(input logic [15:0] cnt);
    @(posedge clk_i); #1;
    req_we_i = 1'b1; req_cnt_i = cnt;
    @(posedge clk_i); #1;
    req_we_i = 1'b0; req_cnt_i = '0;
  endtask

  // MSB first (R4); each bit is checked to be requested
  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      @(posedge clk_i); #1;
      chk(shift_req_o, "R2 request high during byte", 32'(shift_req_o), 32'd1);
      rx_bit_vld_i = 1'b1; rx_bit_i = b[i];
    end
    @(posedge clk_i); #1;
    rx_bit_vld_i = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk(todo_o == 0, "R1 todo", 32'(todo_o), 0);
    chk(!shift_req_o && !push_o && !done_o, "R1 outputs idle",
        {29'd0, shift_req_o, push_o, done_o}, 0);
    chk(stat_o == 0, "R1 status", stat_o, 0);
    chk(tx_bit_o == 1'b1, "R11 idle level", 32'(tx_bit_o), 1);
    write_req(16'd0);
    @(negedge clk_i);
    chk(!shift_req_o && todo_o == 0, "R2 zero write ignored", 32'(todo_o), 0);
  endtask

  task automatic t_full_word();
    clear_caps();
    write_req(16'd4);
    @(negedge clk_i);
    chk(todo_o == 16'd4 && shift_req_o, "R2 load", 32'(todo_o), 4);
    chk(stat_o[13], "R11 busy", stat_o, 32'h2000);
    send_byte(8'hA1);
    @(negedge clk_i);
    chk(todo_o == 16'd3, "R3 decrement", 32'(todo_o), 3);
    send_byte(8'hB2);
    send_byte(8'hC3);
    // last bit latched at the edge before this negedge
    send_byte(8'hD4);
    @(negedge clk_i);
    chk(!shift_req_o && todo_o == 0, "R2 request drops after last bit", 32'(shift_req_o), 0);
    chk(!push_o, "R5 push not yet", 32'(push_o), 0);
    @(negedge clk_i);
    chk(push_o && push_data_o == 32'hA1B2C3D4, "R5 push timing and data R4", push_data_o, 32'hA1B2C3D4);
    chk(done_o, "R9 done with last word", 32'(done_o), 1);
    settle();
    chk(cap_n == 1 && done_n == 1, "R9 single word single pulse", 32'(cap_n * 16 + done_n), 32'h11);
    chk(cap_bv[0] == 3'd4 && stat_o[30:28] == 3'd4, "R7 full count", 32'(stat_o[30:28]), 4);
    chk(!stat_o[13], "R11 not busy", stat_o, 0);
  endtask

  task automatic t_partial();
    clear_caps();
    write_req(16'd6);
    for (int k = 0; k < 6; k++) send_byte(8'h11 + 8'(k));
    settle();
    chk(cap_n == 2, "R6 two words", 32'(cap_n), 2);
    chk(cap_data[0] == 32'h11121314 && cap_bv[0] == 3'd4, "R5 first word", cap_data[0], 32'h11121314);
    chk(cap_data[1] == 32'h00001516, "R6 short word right-justified", cap_data[1], 32'h00001516);
    chk(cap_bv[1] == 3'd2 && stat_o[30:28] == 3'd2, "R7 short count held", 32'(stat_o[30:28]), 2);
    chk(done_n == 1, "R9 one pulse", 32'(done_n), 1);
  endtask

  task automatic t_single();
    clear_caps();
    write_req(16'd1);
    send_byte(8'h5C);
    settle();
    chk(cap_n == 1 && cap_data[0] == 32'h0000005C, "R6 single byte", cap_data[0], 32'h5C);
    chk(cap_bv[0] == 3'd1, "R7 one valid", 32'(cap_bv[0]), 1);
  endtask

  task automatic t_overflow();
    clear_caps();
    fifo_full_i = 1'b1;
    write_req(16'd4);
    for (int k = 0; k < 4; k++) send_byte(8'hE0 + 8'(k));
    settle();
    chk(cap_n == 0, "R8 no push when full", 32'(cap_n), 0);
    chk(stat_o[9], "R8 overflow flag", stat_o, 32'h200);
    chk(done_n == 1, "R9 done on dropped word", 32'(done_n), 1);
    fifo_full_i = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(stat_o[9], "R8 flag sticky", stat_o, 32'h200);
    @(posedge clk_i); #1; err_clr_i = 1'b1;
    @(posedge clk_i); #1; err_clr_i = 1'b0;
    @(negedge clk_i);
    chk(!stat_o[9], "R8 flag cleared", stat_o, 0);
  endtask

  task automatic t_accum();
    clear_caps();
    write_req(16'd2);
    send_byte(8'h55);
    write_req(16'd3);
    @(negedge clk_i);
    chk(todo_o == 16'd4, "R10 add to remaining", 32'(todo_o), 4);
    send_byte(8'h66); send_byte(8'h77); send_byte(8'h88); send_byte(8'h99);
    settle();
    chk(cap_n == 2 && cap_data[0] == 32'h55667788, "R10 merged word", cap_data[0], 32'h55667788);
    chk(cap_data[1] == 32'h00000099 && cap_bv[1] == 3'd1, "R6 tail after merge", cap_data[1], 32'h99);
    chk(done_n == 1, "R9 one pulse merged", 32'(done_n), 1);
  endtask

  task automatic t_saturate();
    write_req(16'hFFFF);
    write_req(16'h0010);
    @(negedge clk_i);
    chk(todo_o == 16'hFFFF, "R10 saturate", 32'(todo_o), 32'hFFFF);
    chk(shift_req_o && stat_o[13], "R11 busy while pending", stat_o, 32'h2000);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    t_reset();
    t_full_word();
    t_partial();
    t_single();
    t_overflow();
    t_accum();
    t_saturate();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule